// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital controller that sits next to a successive-approximation A/D converter in a microcontroller. Software reaches it through a small register port. One control register holds a start bit, a read-only busy/end-of-conversion flag, a three-bit pin-configuration field and a three-bit channel field. A second register holds the A/D clock divider select. The analog sample-and-hold, the DAC and the comparator sit outside the block. The block sees the comparator as a single input bit, and it presents the trial code to the DAC.

A conversion is launched by writing the start bit low, then high, then low. The rising write arms the converter and aborts any conversion in progress. The falling write begins a conversion. Every conversion lasts a fixed 76 A/D clock periods. The first 32 of these are the sampling window. After that, the result bits are resolved one per A/D clock, most significant bit first. The result register changes only when the conversion ends. Completion can be observed in two ways: by polling the flag, or through a single-cycle interrupt request that is gated by an enable input. A pin-configuration value of zero powers the converter down.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, both registers read 0, `result_o` is 0, `irq_o` is 0 and `pwr_en_o` is 0.
- R2: The control register sits at address 0. Its fields are: bit 7 start, bit 6 busy flag, bits 5:3 pin configuration (on `pin_cfg_o`), bits 2:0 channel (on `chan_o`). Bit 6 is read-only, and writes to it are ignored. The clock register sits at address 1 and uses bits 1:0.
- R3: A write that moves the start bit from 0 to 1 arms the converter and sets the flag. A write that moves it from 1 to 0 starts a conversion only if the converter is armed. A falling write with no preceding armed state starts nothing.
- R4: The flag stays high from the arming write until exactly 76×D system clocks after the starting write, where D is the divider. It is low at that point.
- R5: Clock code 00 gives D=2, 01 gives D=8, and both 10 and 11 give D=32. The code is latched when a conversion starts.
- R6: `sample_o` is high for the first 32×D system clocks after the starting write and low after that.
- R7: The result bits are resolved MSB first. When the sampling window closes, the first trial code is 0x80. The final result is the binary search over `cmp_i` (1 when the input is at or above the trial code). `result_o` changes only at the end of a conversion.
- R8: At the end of a conversion, `irq_o` pulses for exactly one cycle if `irq_en_i` is high. It stays low if `irq_en_i` is low.
- R9: A rising start write during a conversion aborts it. The flag stays high, no result or interrupt is produced, and timing restarts from the next falling write.
- R10: A pin configuration of 000 drives `pwr_en_o` low, clears the flag, aborts any conversion and ignores start edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 clock |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_en_i | input | 1 | Interrupt enable from the interrupt controller |
| cmp_i | input | 1 | Comparator output |
| dac_code_o | output | RES_W | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold tracking |
| pwr_en_o | output | 1 | Converter power enable |
| pin_cfg_o | output | 3 | Pin configuration field |
| chan_o | output | 3 | Analog channel select |
| result_o | output | RES_W | Conversion result |
| irq_o | output | 1 | One-cycle completion interrupt request |

## Verification
The hardest case to reach is a converter that was armed while powered down and is then powered up and released. The bench sets the start bit while the pin configuration is 000. It then enables the pins with the start bit still high and writes the start bit low. It then checks that the flag never rises over a long window. Aborts are provoked by re-arming partway through a run. The bench then confirms that neither the result nor the interrupt moves before the restarted conversion ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_START  = 7;
  localparam int BIT_BUSY   = 6;
  localparam int CFG_LSB    = 3;
  localparam int CHAN_LSB   = 0;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CLK  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CLK_FAST = 2'b00,
    CLK_MID  = 2'b01,
    CLK_SLOW = 2'b10,
    CLK_ALT  = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [2:0]       pin_cfg_o,
  output logic [2:0]       chan_o,
  output logic [1:0]       clk_sel_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic       start_q;
  logic [2:0] cfg_q, chan_q;
  logic [1:0] sel_q;
  logic       ctrl_wr, clk_wr;
  logic       unused_wbits;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign clk_wr  = we_i && (addr_i == ADDR_CLK);
  assign rise_o  = ctrl_wr &&  wdata_i[BIT_START] && !start_q;
  assign fall_o  = ctrl_wr && !wdata_i[BIT_START] &&  start_q;
  assign unused_wbits = wdata_i[BIT_BUSY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      cfg_q   <= '0;
      chan_q  <= '0;
      sel_q   <= CLK_FAST;
    end else begin
      if (ctrl_wr) begin
        start_q <= wdata_i[BIT_START];
        cfg_q   <= wdata_i[CFG_LSB +: 3];
        chan_q  <= wdata_i[CHAN_LSB +: 3];
      end
      if (clk_wr) sel_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[BIT_START]       = start_q;
      rdata_o[BIT_BUSY]        = busy_i;
      rdata_o[CFG_LSB +: 3]    = cfg_q;
      rdata_o[CHAN_LSB +: 3]   = chan_q;
    end else begin
      rdata_o[1:0] = sel_q;
    end
  end

  assign pin_cfg_o = cfg_q;
  assign chan_o    = chan_q;
  assign clk_sel_o = sel_q;

  assert_rise_sets_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> start_q);
  assert_fall_clears_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !start_q);
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_seq_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int CW = $clog2(DIV_SLOW + 1);

  logic [CW-1:0] div_q, div_d, cnt_q;

  always_comb begin
    case (clk_sel_e'(sel_i))
      CLK_FAST: div_d = CW'(DIV_FAST);
      CLK_MID:  div_d = CW'(DIV_MID);
      default:  div_d = CW'(DIV_SLOW);
    endcase
  end

  assign tick_o = en_i && (cnt_q == div_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= CW'(DIV_FAST);
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_d;
      cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_tick_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SAMPLE_CLKS = 32,
  parameter int TOTAL_CLKS  = 76
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  input  logic             irq_en_i,
  output logic             load_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  localparam int CNT_W = $clog2(TOTAL_CLKS);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] ad_cnt_q, bit_off;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] sar_q, res_q, trial;
  logic             busy_q, irq_q, in_bits, last_tick, done;

  assign bit_off   = ad_cnt_q - CNT_W'(SAMPLE_CLKS);
  assign bit_idx   = IDX_W'(RES_W - 1) - bit_off[IDX_W-1:0];
  assign in_bits   = (state_q == ST_RUN) && (ad_cnt_q >= CNT_W'(SAMPLE_CLKS)) &&
                     (ad_cnt_q < CNT_W'(SAMPLE_CLKS + RES_W));
  assign trial     = in_bits ? (sar_q | (RES_W'(1) << bit_idx)) : sar_q;
  assign last_tick = tick_i && (ad_cnt_q == CNT_W'(TOTAL_CLKS - 1));
  assign load_o    = pwr_i && !rise_i && fall_i && (state_q == ST_ARMED);
  assign done      = pwr_i && !rise_i && (state_q == ST_RUN) && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ad_cnt_q <= '0;
      sar_q    <= '0;
      res_q    <= '0;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else if (!pwr_i) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (rise_i) begin
        state_q  <= ST_ARMED;
        busy_q   <= 1'b1;
        ad_cnt_q <= '0;
        sar_q    <= '0;
      end else if (load_o) begin
        state_q  <= ST_RUN;
        ad_cnt_q <= '0;
        sar_q    <= '0;
      end else if (state_q == ST_RUN && tick_i) begin
        ad_cnt_q <= ad_cnt_q + CNT_W'(1);
        if (in_bits) sar_q[bit_idx] <= cmp_i;
        if (last_tick) begin
          res_q   <= sar_q;
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
          irq_q   <= irq_en_i;
        end
      end
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign busy_o     = busy_q;
  assign sample_o   = (state_q == ST_RUN) && (ad_cnt_q < CNT_W'(SAMPLE_CLKS));
  assign dac_code_o = trial;
  assign result_o   = res_q;
  assign irq_o      = irq_q;

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(irq_en_i));
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(res_q));
  assert_sample_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_q);
  assert_pwr_off_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> !busy_q && !run_o);
  assert_abort_keeps_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && rise_i) |=> busy_q && !run_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SAMPLE_CLKS = 32,
  parameter int TOTAL_CLKS  = 76,
  parameter int DIV_FAST    = 2,
  parameter int DIV_MID     = 8,
  parameter int DIV_SLOW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             irq_en_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic             pwr_en_o,
  output logic [2:0]       pin_cfg_o,
  output logic [2:0]       chan_o,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  logic       busy, rise, fall, tick, load, run;
  logic [1:0] clk_sel;
  logic [2:0] cfg;

  adc_ctrl_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .rdata_o(reg_rdata_o),
    .pin_cfg_o(cfg), .chan_o(chan_o), .clk_sel_o(clk_sel),
    .rise_o(rise), .fall_o(fall)
  );

  assign pwr_en_o  = |cfg;
  assign pin_cfg_o = cfg;

  adc_clk_div #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk_i, .rst_ni, .load_i(load), .en_i(run), .sel_i(clk_sel), .tick_o(tick)
  );

  adc_sar_core #(.RES_W(RES_W), .SAMPLE_CLKS(SAMPLE_CLKS), .TOTAL_CLKS(TOTAL_CLKS)) u_core (
    .clk_i, .rst_ni,
    .pwr_i(pwr_en_o), .rise_i(rise), .fall_i(fall), .tick_i(tick),
    .cmp_i, .irq_en_i,
    .load_o(load), .run_o(run), .busy_o(busy), .sample_o,
    .dac_code_o, .result_o, .irq_o
  );
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq_en = 1'b0, cmp;
  logic [7:0] dac, result;
  logic       sample, pwr_en, irq;
  logic [2:0] pin_cfg, chan;
  logic [7:0] analog = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign cmp = (analog >= dac);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_en_i(irq_en),
    .cmp_i(cmp), .dac_code_o(dac), .sample_o(sample), .pwr_en_o(pwr_en),
    .pin_cfg_o(pin_cfg), .chan_o(chan), .result_o(result), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 1'b0;
  endtask

  function automatic int div_of(input int code);
    return (code == 0) ? 2 : (code == 1) ? 8 : 32;
  endfunction

  localparam logic [7:0] BASE = 8'b0_0_001_010;

  task automatic run_conv(input int code, input logic [7:0] a, input bit en);
    int d, n;
    logic [7:0] prev;
    d = div_of(code); n = 76 * d;
    analog = a; irq_en = en;
    wr(1'b1, 8'(code));
    wr(1'b0, BASE | 8'h80);
    chk(reg_rdata[6] == 1'b1, "R3 arm sets flag", int'(reg_rdata[6]), 1);
    prev = result;
    wr(1'b0, BASE);
    for (int m = 1; m <= n; m++) begin
      @(negedge clk);
      if (m == 32 * d - 1) chk(sample == 1'b1, "R6 sampling open", int'(sample), 1);
      if (m == 32 * d) begin
        chk(sample == 1'b0, "R6 sampling closed", int'(sample), 0);
        chk(dac == 8'h80, "R7 MSB trial first", int'(dac), 128);
      end
      if (m == n - 1) begin
        chk(reg_rdata[6] == 1'b1, "R4/R5 busy until end", int'(reg_rdata[6]), 1);
        chk(result == prev, "R7 result held", int'(result), int'(prev));
        chk(irq == 1'b0, "R8 no early irq", int'(irq), 0);
      end
      if (m == n) begin
        chk(reg_rdata[6] == 1'b0, "R4/R5 flag clears on time", int'(reg_rdata[6]), 0);
        chk(result == a, "R7 result", int'(result), int'(a));
        chk(irq == en, "R8 irq gated", int'(irq), int'(en));
      end
    end
    @(negedge clk);
    chk(irq == 1'b0, "R8 single pulse", int'(irq), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reg_addr = 1'b0;
    #1;
    chk(reg_rdata == 8'h00, "R1 ctrl reset", int'(reg_rdata), 0);
    chk(result == 8'h00 && irq == 1'b0 && pwr_en == 1'b0, "R1 outputs reset", int'(result), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 8'h00, "R1 clk reg reset", int'(reg_rdata), 0);
    reg_addr = 1'b0;

    // R2: field placement; busy bit is read-only
    wr(1'b0, BASE | 8'h40);
    chk(reg_rdata == BASE, "R2 busy bit ignored on write", int'(reg_rdata), int'(BASE));
    chk(pin_cfg == 3'b001 && chan == 3'b010, "R2 fields", int'({pin_cfg, chan}), 8'b001010);
    chk(pwr_en == 1'b1, "R10 powered when cfg nonzero", int'(pwr_en), 1);
    wr(1'b1, 8'hFF);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 8'h03, "R2 clk reg bits", int'(reg_rdata), 3);
    reg_addr = 1'b0;

    // R5: every divider code
    for (int c = 0; c < 4; c++) run_conv(c, 8'(37 * c + 91), bit'(c[0]));

    // R7/R8: near-exhaustive value sweep at the fast clock
    for (int v = 0; v < 256; v += 3) run_conv(0, 8'(v), bit'(v[1]));
    run_conv(0, 8'hFF, 1'b1);

    // R9: abort mid-run
    begin
      logic [7:0] held;
      held = result;
      analog = 8'h5A; irq_en = 1'b1;
      wr(1'b1, 8'h00);
      wr(1'b0, BASE | 8'h80);
      wr(1'b0, BASE);
      repeat (60) @(negedge clk);
      wr(1'b0, BASE | 8'h80);
      for (int m = 0; m < 200; m++) begin
        @(negedge clk);
        if (irq || result != held || !reg_rdata[6]) begin
          chk(1'b0, "R9 abort holds", int'(result), int'(held));
          break;
        end
      end
      chk(reg_rdata[6] == 1'b1 && result == held, "R9 aborted no result", int'(result), int'(held));
      run_conv(0, 8'hC3, 1'b1);
    end

    // R10: power-down forces idle and ignores start edges
    begin
      logic [7:0] held;
      bit seen;
      wr(1'b0, BASE | 8'h80);
      wr(1'b0, BASE);
      repeat (20) @(negedge clk);
      wr(1'b0, 8'b0_0_000_010);
      chk(pwr_en == 1'b0, "R10 power off", int'(pwr_en), 0);
      @(negedge clk);
      chk(reg_rdata[6] == 1'b0, "R10 flag cleared", int'(reg_rdata[6]), 0);
      held = result; seen = 0;
      wr(1'b0, 8'b1_0_000_010);
      wr(1'b0, 8'b1_0_001_010);   // power up while armed bit still high
      wr(1'b0, 8'b0_0_001_010);   // falling edge without arming: R3
      for (int m = 0; m < 400; m++) begin
        @(negedge clk);
        if (reg_rdata[6] || irq || sample) seen = 1;
      end
      chk(!seen, "R3 unarmed fall starts nothing", int'(seen), 0);
      chk(result == held, "R10 result kept", int'(result), int'(held));
      run_conv(1, 8'h2E, 1'b0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule